// File: doc/BRIEF.md
# Protect Pointer Controller

This block manages the protect pointer of a serial nonvolatile memory. The pointer splits the address space in two: every address at or above it is fenced off from programming, and every address below it stays writable. The block takes commands that an instruction decoder upstream has already decoded. Each command arrives as a one-cycle strobe with an operation code and an address. The block also samples the program-enable pin, the protect-enable pin and the global erase/write-enable flag. It returns three things: a registered "protected" verdict for any address put on the query input, a flag showing that no pointer is stored, and a serial output that streams the stored pointer.

Changing the pointer takes two steps. First an arming command runs. It is accepted only when both pins are high and erase/write is enabled. It arms exactly the next command, so any other command in between disarms it. An armed clear empties the register. An armed store writes a new pointer, and only into an empty register. An armed lock freezes the pointer for good. A read streams a zero start bit and then the pointer, most significant bit first. Each bit advances on a serial-clock rising-edge strobe.

Top module: `prot_reg_ctrl`

## Requirements
- R1: After a synchronous reset, cleared_o is 1, prot_o is 0 and sdo_o is 1. The block is unarmed and unlocked.
- R2: Operation codes on cmd_op are: 0 other, 1 arm, 2 clear, 3 store, 4 lock, 5 read. An arm command is accepted only when wr_en, pe_pin and pre_pin are all 1 in its cycle.
- R3: Clear, store and lock take effect only if the command strobe just before them was an accepted arm. Any other command in between, including a rejected arm, a read or code 0, cancels the arming.
- R4: Clear, store and lock have no effect unless pe_pin and pre_pin are both 1 in the cycle the command is strobed. The pins are ignored in all other cycles.
- R5: An accepted clear sets cleared_o to 1, and from then on no address is protected.
- R6: An accepted store keeps cmd_addr as the pointer and clears cleared_o. prot_o is then 1 for a query address greater than or equal to the pointer and 0 below it. prot_o reflects query_addr one clock after it is applied.
- R7: A store is rejected, with the pointer and cleared_o unchanged, if the register is not cleared when the store arrives.
- R8: After an accepted lock, no later clear or store changes the pointer or cleared_o. The lock cannot be undone except by reset.
- R9: A read with pre_pin at 1 drives sdo_o to 0 in the next cycle. Each sclk_rise strobe after that drives the next pointer bit, most significant bit first. After the last bit, sdo_o holds its value.
- R10: While a read is in progress, pre_pin at 0 ends it, and sdo_o returns to 1 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | One-cycle strobe for a decoded command |
| cmd_op | input | 3 | Operation code |
| cmd_addr | input | ADDR_W | Address carried by a store command |
| pe_pin | input | 1 | Program-enable pin level |
| pre_pin | input | 1 | Protect-enable pin level |
| wr_en | input | 1 | Global erase/write-enable flag |
| sclk_rise | input | 1 | Serial-clock rising-edge strobe |
| query_addr | input | ADDR_W | Address whose protection is asked |
| prot_o | output | 1 | Registered verdict: query address is protected |
| cleared_o | output | 1 | No pointer stored |
| sdo_o | output | 1 | Serial read output |

## Verification
The assertions check, on every cycle, several rules. The lock never falls, and once locked the pointer and the cleared flag stay frozen. The arming flag rises only after a qualifying arm command. The cleared flag changes only after a clear or store strobed with both pins high. A read start drives the zero start bit, and the serial output stays still between clock strobes. What only the bench scenarios can show is ordering that spans several commands: arming cancelled by an intervening command, a store refused into a non-empty register, the greater-or-equal comparison against random query addresses, and the exact bit order of a read.

// File: rtl/prot_pkg.sv
package prot_pkg;
  typedef enum logic [2:0] {
    OP_OTHER = 3'd0,
    OP_ARM   = 3'd1,
    OP_CLR   = 3'd2,
    OP_SET   = 3'd3,
    OP_LOCK  = 3'd4,
    OP_READ  = 3'd5
  } prot_op_e;
endpackage

// File: rtl/prot_arm.sv
module prot_arm
  import prot_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       cmd_valid,
  input  logic [2:0] cmd_op,
  input  logic       pe_pin,
  input  logic       pre_pin,
  input  logic       wr_en,
  input  logic       valid,
  input  logic       locked,
  output logic       armed,
  output logic       do_clr,
  output logic       do_set,
  output logic       do_lock,
  output logic       do_read
);
  logic pins_ok;
  logic fire;

  assign pins_ok = pe_pin && pre_pin;
  assign fire    = cmd_valid && pins_ok && armed && !locked;

  always_comb begin
    do_clr  = fire && (cmd_op == OP_CLR);
    do_set  = fire && (cmd_op == OP_SET) && !valid;
    do_lock = fire && (cmd_op == OP_LOCK);
    do_read = cmd_valid && (cmd_op == OP_READ) && pre_pin;
  end

  always_ff @(posedge clk) begin
    if (rst)
      armed <= 1'b0;
    else if (cmd_valid)
      armed <= (cmd_op == OP_ARM) && wr_en && pins_ok;
  end
endmodule

// File: rtl/prot_store.sv
module prot_store #(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              do_clr,
  input  logic              do_set,
  input  logic              do_lock,
  input  logic [ADDR_W-1:0] set_addr,
  input  logic [ADDR_W-1:0] query_addr,
  output logic [ADDR_W-1:0] ptr,
  output logic              valid,
  output logic              locked,
  output logic              prot
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ptr    <= '0;
      valid  <= 1'b0;
      locked <= 1'b0;
      prot   <= 1'b0;
    end else begin
      if (do_clr) begin
        ptr   <= '0;
        valid <= 1'b0;
      end else if (do_set) begin
        ptr   <= set_addr;
        valid <= 1'b1;
      end
      if (do_lock)
        locked <= 1'b1;
      prot <= valid && (query_addr >= ptr);
    end
  end
endmodule

// File: rtl/prot_reader.sv
module prot_reader #(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              pre_pin,
  input  logic              sclk_rise,
  input  logic [ADDR_W-1:0] ptr,
  output logic              sdo
);
  localparam int CNT_W = $clog2(ADDR_W + 1);

  logic [ADDR_W-1:0] shreg;
  logic [CNT_W-1:0]  left;
  logic              active;

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg  <= '0;
      left   <= '0;
      active <= 1'b0;
      sdo    <= 1'b1;
    end else if (start) begin
      shreg  <= ptr;
      left   <= CNT_W'(ADDR_W);
      active <= 1'b1;
      sdo    <= 1'b0;
    end else if (active && !pre_pin) begin
      active <= 1'b0;
      sdo    <= 1'b1;
    end else if (active && sclk_rise && (left != '0)) begin
      sdo   <= shreg[ADDR_W-1];
      shreg <= {shreg[ADDR_W-2:0], 1'b0};
      left  <= left - 1'b1;
    end
  end
endmodule

// File: rtl/prot_reg_ctrl.sv
module prot_reg_ctrl #(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic              pe_pin,
  input  logic              pre_pin,
  input  logic              wr_en,
  input  logic              sclk_rise,
  input  logic [ADDR_W-1:0] query_addr,
  output logic              prot_o,
  output logic              cleared_o,
  output logic              sdo_o
);
  logic              arm_q, lock_q, valid_q;
  logic              do_clr, do_set, do_lock, do_read;
  logic [ADDR_W-1:0] ptr_q;

  prot_arm u_arm (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .pe_pin(pe_pin), .pre_pin(pre_pin), .wr_en(wr_en),
    .valid(valid_q), .locked(lock_q), .armed(arm_q),
    .do_clr(do_clr), .do_set(do_set), .do_lock(do_lock), .do_read(do_read)
  );

  prot_store #(.ADDR_W(ADDR_W)) u_store (
    .clk(clk), .rst(rst), .do_clr(do_clr), .do_set(do_set),
    .do_lock(do_lock), .set_addr(cmd_addr), .query_addr(query_addr),
    .ptr(ptr_q), .valid(valid_q), .locked(lock_q), .prot(prot_o)
  );

  prot_reader #(.ADDR_W(ADDR_W)) u_reader (
    .clk(clk), .rst(rst), .start(do_read), .pre_pin(pre_pin),
    .sclk_rise(sclk_rise), .ptr(ptr_q), .sdo(sdo_o)
  );

  assign cleared_o = !valid_q;
endmodule

// File: rtl/prot_reg_chk.sv
module prot_reg_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              cmd_valid,
  input logic [2:0]        cmd_op,
  input logic              pe_pin,
  input logic              pre_pin,
  input logic              wr_en,
  input logic              sclk_rise,
  input logic              cleared_o,
  input logic              sdo_o,
  input logic              arm_q,
  input logic              lock_q,
  input logic [ADDR_W-1:0] ptr_q
);
  assert_lock_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    lock_q |=> lock_q);

  assert_lock_freezes_R8: assert property (@(posedge clk) disable iff (rst)
    lock_q |=> ($stable(ptr_q) && $stable(cleared_o)));

  assert_arm_source_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(arm_q) |-> $past(cmd_valid && cmd_op == 3'd1 && wr_en && pe_pin && pre_pin));

  assert_store_source_R6: assert property (@(posedge clk) disable iff (rst)
    $fell(cleared_o) |-> $past(cmd_valid && cmd_op == 3'd3 && pe_pin && pre_pin));

  assert_clear_source_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(cleared_o) |-> $past(cmd_valid && cmd_op == 3'd2 && pe_pin && pre_pin));

  assert_read_start_R9: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_op == 3'd5 && pre_pin) |=> !sdo_o);

  assert_read_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (!sclk_rise && pre_pin && !(cmd_valid && cmd_op == 3'd5)) |=> $stable(sdo_o));
endmodule

bind prot_reg_ctrl prot_reg_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
  .pe_pin(pe_pin), .pre_pin(pre_pin), .wr_en(wr_en), .sclk_rise(sclk_rise),
  .cleared_o(cleared_o), .sdo_o(sdo_o), .arm_q(arm_q), .lock_q(lock_q),
  .ptr_q(ptr_q)
);

// File: tb/prot_reg_ctrl_test.sv
module prot_reg_ctrl_test;
  localparam int AW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cmd_valid = 1'b0;
  logic [2:0]    cmd_op = 3'd0;
  logic [AW-1:0] cmd_addr = '0;
  logic          pe_pin = 1'b0, pre_pin = 1'b0, wr_en = 1'b0, sclk_rise = 1'b0;
  logic [AW-1:0] query_addr = '0;
  logic          prot_o, cleared_o, sdo_o;

  int checks = 0;
  int errors = 0;

  // bench model of the protect state
  logic          m_arm = 1'b0, m_valid = 1'b0, m_lock = 1'b0;
  logic [AW-1:0] m_ptr = '0;

  always #2.5 clk = ~clk;

  prot_reg_ctrl #(.ADDR_W(AW)) uut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .pe_pin(pe_pin), .pre_pin(pre_pin), .wr_en(wr_en),
    .sclk_rise(sclk_rise), .query_addr(query_addr), .prot_o(prot_o),
    .cleared_o(cleared_o), .sdo_o(sdo_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic exp_prot(input logic [AW-1:0] q);
    return m_valid && (q >= m_ptr);
  endfunction

  task automatic do_cmd(input logic [2:0] op, input logic [AW-1:0] a,
                        input logic pe, input logic pre, input logic we);
    logic ok;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_addr = a;
    pe_pin = pe; pre_pin = pre; wr_en = we;
    ok = pe && pre && m_arm && !m_lock;
    if (ok && op == 3'd2) begin m_valid = 1'b0; m_ptr = '0; end
    if (ok && op == 3'd3 && !m_valid) begin m_valid = 1'b1; m_ptr = a; end
    if (ok && op == 3'd4) m_lock = 1'b1;
    m_arm = (op == 3'd1) && we && pe && pre;
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0; pe_pin = 1'b0; pre_pin = 1'b0;
  endtask

  task automatic check_state(input string req, input logic [AW-1:0] q);
    @(negedge clk);
    query_addr = q;
    @(posedge clk);
    #1;
    check(req, {31'd0, cleared_o}, {31'd0, !m_valid});
    check(req, {31'd0, prot_o}, {31'd0, exp_prot(q)});
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed1234));
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    #1;
    // R1 reset state
    check("R1", {29'd0, cleared_o, prot_o, sdo_o}, {29'd0, 3'b101});
    check_state("R1", 8'hff);

    // R2: arm refused without wr_en, so store does nothing
    do_cmd(3'd1, 0, 1, 1, 0);
    do_cmd(3'd3, 8'h40, 1, 1, 1);
    check_state("R2", 8'h80);

    // R6: proper arm and store
    do_cmd(3'd1, 0, 1, 1, 1);
    do_cmd(3'd3, 8'h40, 1, 1, 1);
    check_state("R6", 8'h40);
    check_state("R6", 8'h3f);
    check_state("R6", 8'hff);

    // R7: store into non-empty register refused
    do_cmd(3'd1, 0, 1, 1, 1);
    do_cmd(3'd3, 8'h10, 1, 1, 1);
    check_state("R7", 8'h20);

    // R3: read between arm and clear cancels arming
    do_cmd(3'd1, 0, 1, 1, 1);
    do_cmd(3'd5, 0, 1, 1, 1);
    do_cmd(3'd2, 0, 1, 1, 1);
    check_state("R3", 8'h40);

    // R4: clear with pe low has no effect
    do_cmd(3'd1, 0, 1, 1, 1);
    do_cmd(3'd2, 0, 0, 1, 1);
    check_state("R4", 8'h40);

    // R5: clear
    do_cmd(3'd1, 0, 1, 1, 1);
    do_cmd(3'd2, 0, 1, 1, 1);
    check_state("R5", 8'hff);

    // R9: read streams 0 then pointer MSB first
    do_cmd(3'd1, 0, 1, 1, 1);
    do_cmd(3'd3, 8'ha5, 1, 1, 1);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 3'd5; pre_pin = 1'b1; m_arm = 1'b0;
    @(negedge clk);
    cmd_valid = 1'b0;
    check("R9 start bit", {31'd0, sdo_o}, 32'd0);
    for (int i = AW - 1; i >= 0; i--) begin
      sclk_rise = 1'b1;
      @(negedge clk);
      sclk_rise = 1'b0;
      check("R9 data bit", {31'd0, sdo_o}, {31'd0, m_ptr[i]});
    end
    sclk_rise = 1'b1;
    @(negedge clk);
    sclk_rise = 1'b0;
    check("R9 hold", {31'd0, sdo_o}, {31'd0, m_ptr[0]});
    // R10: pre low ends read
    pre_pin = 1'b0;
    @(negedge clk);
    check("R10", {31'd0, sdo_o}, 32'd1);

    // random mix
    for (int n = 0; n < 300; n++) begin
      logic [2:0] op;
      op = 3'($urandom % 6);
      if (op == 3'd4 && ($urandom % 40) != 0) op = 3'd1;
      do_cmd(op, 8'($urandom), ($urandom % 5) != 0, ($urandom % 5) != 0,
             ($urandom % 5) != 0);
      check_state("R6 random", 8'($urandom));
    end

    // R8: lock then attempt clear
    do_cmd(3'd1, 0, 1, 1, 1);
    do_cmd(3'd4, 0, 1, 1, 1);
    do_cmd(3'd1, 0, 1, 1, 1);
    do_cmd(3'd2, 0, 1, 1, 1);
    check_state("R8", m_ptr);
    do_cmd(3'd1, 0, 1, 1, 1);
    do_cmd(3'd3, 8'h01, 1, 1, 1);
    check_state("R8", 8'h01);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule